// File: doc/BRIEF.md
# Dual-Channel Converter Serial Port and Power-Mode Controller

This block is the digital side of a two-channel, 14-bit sampling converter's serial port. A host frames each transfer with an active-low select line and a serial clock. The block counts serial-clock falling edges from the moment select drops. It uses the count at which select returns high to decide the power mode. It also shifts the two channel results out on two data lines. Each line carries its own channel first and can carry the other channel after it. Each data line has an enable, so an enclosing pad ring can release the line. Both results arrive as parallel words and are captured when select falls.

All inputs are sampled on a fast system clock, and edges are detected from the sampled values. The time a powered-down part takes to wake is modelled as a fixed number of system-clock cycles. A status output reports the power mode, and a flag marks a frame that carries a valid result.

Top module: `dualAdcPort`

## Requirements
- R1: After reset, mode reads 2'b00 (normal), both line enables are low and dataValid is low.
- R2: One system clock after select is sampled high, both line enables are low and dataValid is low, so the frame is abandoned.
- R3: If select rises after fewer than 2 serial-clock falling edges, the mode is unchanged.
- R4: From normal (2'b00), a select rise after 2 to 9 falling edges sets mode to partial power-down, 2'b01.
- R5: From partial power-down, a select rise after 2 to 9 falling edges sets mode to full power-down, 2'b10. From full power-down, the same rise leaves it at 2'b10.
- R6: From normal, a select rise after 10 or more falling edges leaves the mode at normal.
- R7: Line A carries a 32-slot stream {2'b00, A[13:0], 2'b00, B[13:0]}, MSB first. Line B carries {2'b00, B, 2'b00, A}. Slot 0 appears once select falls, and slot k appears after the k-th falling edge. The results are captured at the select fall, so later changes on the result inputs do not alter the frame.
- R8: At the 32nd falling edge, both line enables drop even while select stays low.
- R9: In partial or full power-down, holding select low through the 10th falling edge sets mode to waking, 2'b11. After WAKE_CYCLES system clocks in that state, the mode becomes normal. Power-down modes never step directly to normal.
- R10: A select rise while the mode is waking returns the mode to partial power-down.
- R11: dataValid is high only while the lines are driven in a frame that began in normal mode. It stays low in every dummy frame that starts in a power-down mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples select and serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock; falling edges advance the frame |
| resultA | input | 14 | Channel A conversion result |
| resultB | input | 14 | Channel B conversion result |
| sdoA | output | 1 | Data line A |
| sdoAEn | output | 1 | Drive enable for line A (low = released) |
| sdoB | output | 1 | Data line B |
| sdoBEn | output | 1 | Drive enable for line B (low = released) |
| mode | output | 2 | Power mode: 00 normal, 01 partial, 10 full, 11 waking |
| dataValid | output | 1 | Current frame carries a valid result |

## Verification
The bench aims at the window boundaries: rises after 1, 2, 9 and 10 falling edges. A design with an off-by-one window would either power down on a select glitch or keep power when it should drop it. Frames of 16, 18, 32 and 34 edges check that the second result follows the two pad zeros and that the lines release by themselves at edge 32. A model that kept driving, or kept shifting zeros, would fail these checks. Dummy frames that start in each power-down mode cover several cases. Stopping at 10 or 11 edges must fall back to partial. Running on to 16 must wake to normal with dataValid held low. Changing the result inputs after select falls exposes a design that samples late.

// File: rtl/dualAdcPortPkg.sv
package dualAdcPortPkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_PARTIAL = 2'b01,
    MODE_FULL    = 2'b10,
    MODE_WAKING  = 2'b11
  } pwrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // select fell: capture results, start driving
    logic shift;      // serial falling edge inside the frame
    logic halt;       // release the lines
    logic loadValid;  // frame starts in a powered state
  } dpStrobe_t;

endpackage

// File: rtl/dualAdcPortCtrl.sv
module dualAdcPortCtrl
  import dualAdcPortPkg::*;
#(
  parameter int GLITCH_EDGES = 2,
  parameter int KEEP_EDGES   = 10,
  parameter int FRAME_EDGES  = 32,
  parameter int WAKE_CYCLES  = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  output dpStrobe_t strobe,
  output pwrMode_t  mode
);

  localparam int CNT_W  = $clog2(FRAME_EDGES + 1);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic              csPrev, sclkPrev, inFrame;
  logic [CNT_W-1:0]  fallCnt;
  logic [CNT_W-1:0]  cntNext;
  logic [WAKE_W-1:0] wakeCnt;
  pwrMode_t          modeQ;

  logic csFall, csRise, sclkFall, counting, inWindow, lowPower;

  always_comb begin
    csFall   = csPrev & ~csN;
    csRise   = ~csPrev & csN;
    sclkFall = sclkPrev & ~sclk;
    counting = inFrame & ~csN & sclkFall & (fallCnt < CNT_W'(FRAME_EDGES));
    cntNext  = fallCnt + 1'b1;
    inWindow = (fallCnt >= CNT_W'(GLITCH_EDGES)) && (fallCnt < CNT_W'(KEEP_EDGES));
    lowPower = (modeQ == MODE_PARTIAL) || (modeQ == MODE_FULL);
  end

  always_comb begin
    strobe.load      = csFall;
    strobe.shift     = counting;
    strobe.halt      = (csRise & inFrame) | (counting && (cntNext == CNT_W'(FRAME_EDGES)));
    strobe.loadValid = (modeQ == MODE_NORMAL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
      inFrame  <= 1'b0;
      fallCnt  <= '0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      if (csFall) begin
        inFrame <= 1'b1;
        fallCnt <= '0;
      end else if (csRise) begin
        inFrame <= 1'b0;
      end else if (counting) begin
        fallCnt <= cntNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_NORMAL;
      wakeCnt <= '0;
    end else if (csRise && inFrame) begin
      unique case (modeQ)
        MODE_NORMAL:  if (inWindow) modeQ <= MODE_PARTIAL;
        MODE_PARTIAL: if (inWindow) modeQ <= MODE_FULL;
        MODE_FULL:    modeQ <= MODE_FULL;
        MODE_WAKING:  modeQ <= MODE_PARTIAL;
        default:      modeQ <= MODE_NORMAL;
      endcase
    end else if (counting && lowPower && (cntNext == CNT_W'(KEEP_EDGES))) begin
      modeQ   <= MODE_WAKING;
      wakeCnt <= WAKE_W'(WAKE_CYCLES - 1);
    end else if (modeQ == MODE_WAKING) begin
      if (wakeCnt == '0) modeQ <= MODE_NORMAL;
      else               wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign mode = modeQ;

endmodule

// File: rtl/dualAdcPortData.sv
module dualAdcPortData
  import dualAdcPortPkg::*;
#(
  parameter int RES_W = 14,
  parameter int PAD_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [RES_W-1:0] resultA,
  input  logic [RES_W-1:0] resultB,
  output logic [1:0]       sdo,
  output logic             lineEn,
  output logic             dataValid
);

  localparam int SLOT_W = 2 * (PAD_W + RES_W);

  logic [RES_W-1:0] results [2];
  logic             lineEnQ, validQ;

  assign results[0] = resultA;
  assign results[1] = resultB;

  // lane 0 leads with channel A, lane 1 with channel B
  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [SLOT_W-1:0] shiftQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftQ <= '0;
      end else if (strobe.load) begin
        shiftQ <= {{PAD_W{1'b0}}, results[lane], {PAD_W{1'b0}}, results[1-lane]};
      end else if (strobe.shift) begin
        shiftQ <= {shiftQ[SLOT_W-2:0], 1'b0};
      end
    end
    assign sdo[lane] = lineEnQ & shiftQ[SLOT_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineEnQ <= 1'b0;
      validQ  <= 1'b0;
    end else if (strobe.halt) begin
      lineEnQ <= 1'b0;
      validQ  <= 1'b0;
    end else if (strobe.load) begin
      lineEnQ <= 1'b1;
      validQ  <= strobe.loadValid;
    end
  end

  assign lineEn    = lineEnQ;
  assign dataValid = lineEnQ & validQ;

endmodule

// File: rtl/dualAdcPort.sv
module dualAdcPort
  import dualAdcPortPkg::*;
#(
  parameter int RES_W        = 14,
  parameter int GLITCH_EDGES = 2,
  parameter int KEEP_EDGES   = 10,
  parameter int WAKE_CYCLES  = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic [RES_W-1:0] resultA,
  input  logic [RES_W-1:0] resultB,
  output logic             sdoA,
  output logic             sdoAEn,
  output logic             sdoB,
  output logic             sdoBEn,
  output logic [1:0]       mode,
  output logic             dataValid
);

  localparam int PAD_W       = 2;
  localparam int FRAME_EDGES = 2 * (PAD_W + RES_W);

  dpStrobe_t  strobe;
  pwrMode_t   modeInt;
  logic [1:0] sdoInt;
  logic       lineEn;

  dualAdcPortCtrl #(
    .GLITCH_EDGES(GLITCH_EDGES),
    .KEEP_EDGES  (KEEP_EDGES),
    .FRAME_EDGES (FRAME_EDGES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .strobe(strobe),
    .mode  (modeInt)
  );

  dualAdcPortData #(
    .RES_W(RES_W),
    .PAD_W(PAD_W)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .resultA  (resultA),
    .resultB  (resultB),
    .sdo      (sdoInt),
    .lineEn   (lineEn),
    .dataValid(dataValid)
  );

  assign sdoA   = sdoInt[0];
  assign sdoB   = sdoInt[1];
  assign sdoAEn = lineEn;
  assign sdoBEn = lineEn;
  assign mode   = modeInt;

endmodule

// File: rtl/dualAdcPortChk.sv
module dualAdcPortChk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [1:0] mode,
  input logic       sdoAEn,
  input logic       sdoBEn,
  input logic       dataValid
);

  // R2: select high releases both lines by the next edge
  assert_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!sdoAEn && !sdoBEn && !dataValid));

  // R3: normal mode cannot change while select stays low
  assert_glitch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && !csN) |=> (mode == 2'b00));

  // R9: partial power-down never jumps straight to normal
  assert_partial_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01) |=> (mode != 2'b00));

  // R9: full power-down never jumps straight to normal
  assert_full_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10) |=> (mode != 2'b00));

  // R11: valid data only in normal mode
  assert_valid_mode_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (mode == 2'b00));

endmodule

bind dualAdcPort dualAdcPortChk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .mode     (mode),
  .sdoAEn   (sdoAEn),
  .sdoBEn   (sdoBEn),
  .dataValid(dataValid)
);

// File: tb/dualAdcPort_tb_top.sv
module dualAdcPort_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WAKE       = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic [13:0] resultA = '0;
  logic [13:0] resultB = '0;
  logic        sdoA, sdoAEn, sdoB, sdoBEn, dataValid;
  logic [1:0]  mode;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic [1:0] expMode = 2'b00;

  dualAdcPort #(.WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .resultA(resultA), .resultB(resultB),
    .sdoA(sdoA), .sdoAEn(sdoAEn), .sdoB(sdoB), .sdoBEn(sdoBEn),
    .mode(mode), .dataValid(dataValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] predictMode(input logic [1:0] m, input int n);
    if (m == 2'b00) return (n >= 2 && n < 10) ? 2'b01 : 2'b00;
    if (n < 2)  return m;
    if (n < 10) return 2'b10;
    if (n < 12) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string modeReq(input logic [1:0] m, input int n);
    if (n < 2) return "R3";
    if (m == 2'b00) return (n < 10) ? "R4" : "R6";
    if (n < 10) return "R5";
    if (n < 12) return "R10";
    return "R9";
  endfunction

  function automatic bit expBit(input int k, input logic [13:0] own, input logic [13:0] other);
    logic [31:0] s;
    s = {2'b00, own, 2'b00, other};
    return s[31-k];
  endfunction

  task automatic checkSlot(input int k, input logic [13:0] a, input logic [13:0] b,
                           input bit startNormal);
    if (k < 32) begin
      check(sdoAEn && sdoBEn, "R7", "enables", int'(sdoAEn), 1);
      check(sdoA == expBit(k, a, b), "R7", $sformatf("lineA slot %0d", k),
            int'(sdoA), int'(expBit(k, a, b)));
      check(sdoB == expBit(k, b, a), "R7", $sformatf("lineB slot %0d", k),
            int'(sdoB), int'(expBit(k, b, a)));
      check(dataValid == startNormal, "R11", "dataValid in frame",
            int'(dataValid), int'(startNormal));
    end else begin
      check(!sdoAEn && !sdoBEn, "R8", "release after edge 32", int'(sdoAEn), 0);
      check(!dataValid, "R8", "dataValid after edge 32", int'(dataValid), 0);
    end
  endtask

  task automatic runFrame(input int n, input logic [13:0] a, input logic [13:0] b);
    bit startNormal;
    logic [1:0] nextMode;
    startNormal = (expMode == 2'b00);
    resultA = a;
    resultB = b;
    csN = 1'b0;
    waitN(HALF);
    resultA = ~a;  // capture must have happened at the select fall (R7)
    resultB = ~b;
    checkSlot(0, a, b, startNormal);
    for (int k = 1; k <= n; k++) begin
      sclk = 1'b0;
      waitN(HALF);
      sclk = 1'b1;
      waitN(HALF);
      checkSlot(k, a, b, startNormal);
      if (k == 10 && !startNormal)
        check(mode == 2'b11, "R9", "waking after edge 10", int'(mode), 3);
    end
    csN = 1'b1;
    waitN(2);
    check(!sdoAEn && !sdoBEn, "R2", "release on select high", int'(sdoAEn), 0);
    check(!dataValid, "R2", "dataValid on select high", int'(dataValid), 0);
    nextMode = predictMode(expMode, n);
    check(mode == nextMode, modeReq(expMode, n), $sformatf("mode after %0d edges", n),
          int'(mode), int'(nextMode));
    expMode = nextMode;
    waitN(HALF);
  endtask

  function automatic logic [13:0] rnd14();
    return 14'($urandom);
  endfunction

  initial begin
    void'($urandom(32'h5eed_0a5c));
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1: reset state
    check(mode == 2'b00, "R1", "reset mode", int'(mode), 0);
    check(!sdoAEn && !sdoBEn, "R1", "reset enables", int'(sdoAEn), 0);
    check(!dataValid, "R1", "reset dataValid", int'(dataValid), 0);

    // directed corner cases
    runFrame(0, 14'h2aaa, 14'h1555);   // R3 glitch in normal
    runFrame(1, 14'h3fff, 14'h0001);   // R3
    runFrame(16, 14'h2345, 14'h1abc);  // R6 single result
    runFrame(18, 14'h3c0f, 14'h00ff);  // trailing zeros
    runFrame(32, 14'h1234, 14'h2fed);  // R7 dual result
    runFrame(34, 14'h0f0f, 14'h3333);  // R8 select idles low
    runFrame(10, 14'h0400, 14'h0800);  // R6 boundary
    runFrame(9, 14'h0001, 14'h2000);   // R4 boundary
    runFrame(1, 14'h1111, 14'h2222);   // R3 in partial
    runFrame(10, 14'h1111, 14'h2222);  // R9 then R10
    runFrame(11, 14'h0aaa, 14'h0555);  // R10
    runFrame(2, 14'h0f00, 14'h00f0);   // R5 partial -> full
    runFrame(5, 14'h0123, 14'h0321);   // R5 full stays full
    runFrame(16, 14'h3210, 14'h0123);  // R9 full -> normal
    runFrame(2, 14'h1357, 14'h2468);   // R4 boundary
    runFrame(20, 14'h3ace, 14'h1bdf);  // R9 partial -> normal

    // constrained random frames
    for (int i = 0; i < 60; i++) begin
      int n;
      n = int'($urandom_range(0, 36));
      if (expMode != 2'b00 && (n == 12 || n == 13)) n = 14;
      runFrame(n, rnd14(), rnd14());
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule